// File: doc/BRIEF.md
# Serial Command Front End for a Dual Digital Potentiometer

This block is the serial slave side of a controller for two digital potentiometers. The serial pins (select, clock, data in, pause) are brought into the system clock domain through a synchronizer. Data is captured on rising serial clock edges, and the returned byte is shifted out on falling edges. Each frame opens with an identification byte that must carry a fixed 4-bit type code and match the two strapped address pins. An instruction byte follows. It names an operation, one of four registers and one of the two pots. Depending on the operation, the frame then ends, carries a data byte in either direction, or becomes an open-ended stream of single-step wiper moves.

Every decoded operation leaves the block as a one-cycle request on a command stream (`cmd_valid` plus fields). The register bank behind it owns all storage and all write timing. The stream has no ready signal, because a serial master cannot be stalled, so the bank must take every beat in the cycle it is presented. For read operations, the bank answers on `rd_data` in the same cycle that `cmd_valid` is high. The write-in-progress flag arrives on `wip`. The serial data out is presented as a value (`so`) and a drive enable (`so_en`). The pad drives the pin only while `so_en` is high.

The serial clock half-period must be at least SYNC_STAGES+3 system clock cycles.

Top module: `pot_cmd_if`

## Requirements
- R1: The first byte after select falls is accepted only if bits 7..4 equal 0101, bits 3..2 are 00 and bits 1..0 equal `dev_addr`. Otherwise the frame issues no command and never drives `so_en`.
- R2: In the second byte, bits 7..4 are the opcode (`cmd_op`), bits 3..2 the register index (`cmd_reg`) and bit 0 the pot (`cmd_pot`). A 1 in bit 1 causes the frame to be dropped.
- R3: Transfer opcodes 1101, 1110, 0001 and 1000 issue exactly one command after the 16th bit. Any further bits in the frame have no effect.
- R4: Write opcodes 1010 (wiper) and 1100 (data register) issue one command after the 24th bit, with `cmd_data` equal to bits 5..0 of the third byte.
- R5: Read opcodes 1001 (wiper) and 1011 (data register) issue a command after the 16th bit. The third byte then appears on `so` MSB first as 00 followed by the six `rd_data` bits. `so` changes only after falling clock edges, and `so_en` is high from the first falling edge after the instruction byte.
- R6: Opcode 0101 returns a byte whose bits 7..1 are zero and whose bit 0 is `wip`.
- R7: After opcode 0010, every rising clock edge until select rises issues a command with `cmd_up` equal to the data-in level.
- R8: While pause is low, clock edges are ignored and `so_en` is low. Pause is entered or left only while the serial clock is low, and the frame resumes where it stopped.
- R9: A frame ended by select rising before its required bit count issues no command.
- R10: Opcodes outside the ten listed above issue no command and never drive `so_en`.
- R11: `so_en` is low while select is high. After reset, no command is accepted until select has gone from high to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause, active low |
| dev_addr | input | 2 | Strapped device address |
| so | output | 1 | Serial data out value |
| so_en | output | 1 | Drive enable for serial data out |
| cmd_valid | output | 1 | Command stream beat, one cycle |
| cmd_op | output | 4 | Opcode of the command |
| cmd_pot | output | 1 | Pot select |
| cmd_reg | output | 2 | Register index |
| cmd_data | output | 6 | Write data |
| cmd_up | output | 1 | Step direction, 1 = up |
| rd_data | input | 6 | Read answer from the bank, same cycle as cmd_valid |
| wip | input | 1 | Write-in-progress flag from the bank |

## Verification
A command beat appears SYNC_STAGES+1 system cycles after the serial clock edge that completes it. A new `so` bit appears the same number of cycles after a falling edge. The bench therefore waits a full 8-cycle half-period after each edge before it looks at anything. It samples `so` and `so_en` just before the next rising edge, and reads a command log filled by a monitor that records every `cmd_valid` cycle. Because each completed frame is followed by at least two half-periods, a command count read after the frame can neither miss a late beat nor include a beat from the next frame.

// File: rtl/pot_cmd_pkg.sv
package pot_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 6;
  localparam int OP_W   = 4;

  localparam logic [OP_W-1:0] OP_RD_WIPER = 4'b1001;
  localparam logic [OP_W-1:0] OP_WR_WIPER = 4'b1010;
  localparam logic [OP_W-1:0] OP_RD_REG   = 4'b1011;
  localparam logic [OP_W-1:0] OP_WR_REG   = 4'b1100;
  localparam logic [OP_W-1:0] OP_REG2WIP  = 4'b1101;
  localparam logic [OP_W-1:0] OP_WIP2REG  = 4'b1110;
  localparam logic [OP_W-1:0] OP_ALL_R2W  = 4'b0001;
  localparam logic [OP_W-1:0] OP_ALL_W2R  = 4'b1000;
  localparam logic [OP_W-1:0] OP_STEP     = 4'b0010;
  localparam logic [OP_W-1:0] OP_STATUS   = 4'b0101;

  typedef enum logic [2:0] {
    ST_ID, ST_INSTR, ST_DATA, ST_STEP, ST_DONE, ST_DROP
  } frame_st_t;

  function automatic logic op_is_xfer(input logic [OP_W-1:0] op);
    return op == OP_REG2WIP || op == OP_WIP2REG || op == OP_ALL_R2W || op == OP_ALL_W2R;
  endfunction

  function automatic logic op_is_read(input logic [OP_W-1:0] op);
    return op == OP_RD_WIPER || op == OP_RD_REG || op == OP_STATUS;
  endfunction

  function automatic logic op_is_write(input logic [OP_W-1:0] op);
    return op == OP_WR_WIPER || op == OP_WR_REG;
  endfunction
endpackage

// File: rtl/pot_sync.sv
module pot_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg    <= '0;
      q_prev <= '0;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      q_prev <= stg[STAGES-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pot_frame.sv
module pot_frame
  import pot_cmd_pkg::*;
#(
  parameter logic [3:0] TYPE_CODE = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              cs_prev,
  input  logic              sck_s,
  input  logic              sck_rise,
  input  logic              si_s,
  input  logic              hold_s,
  input  logic [1:0]        dev_addr,
  output logic              active,
  output logic              paused,
  output logic              cmd_valid,
  output logic [OP_W-1:0]   cmd_op,
  output logic              cmd_pot,
  output logic [1:0]        cmd_reg,
  output logic [WORD_W-1:0] cmd_data,
  output logic              cmd_up
);
  frame_st_t         st;
  logic [BYTE_W-1:0] sh;
  logic [2:0]        bitn;
  logic [OP_W-1:0]   op_q;
  logic              pot_q;
  logic [1:0]        reg_q;

  logic              cs_fall, take, byte_done, id_ok;
  logic [BYTE_W-1:0] nb;

  assign cs_fall   = cs_prev & ~cs_s;
  assign take      = sck_rise & active & ~paused;
  assign nb        = {sh[BYTE_W-2:0], si_s};
  assign byte_done = take && (bitn == 3'd7);
  assign id_ok     = (nb[7:4] == TYPE_CODE) && (nb[3:2] == 2'b00) && (nb[1:0] == dev_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      paused <= 1'b0;
    end else begin
      if (cs_fall) active <= 1'b1;
      else if (cs_s) active <= 1'b0;
      if (!sck_s) paused <= ~hold_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_ID;
      sh        <= '0;
      bitn      <= '0;
      op_q      <= '0;
      pot_q     <= 1'b0;
      reg_q     <= '0;
      cmd_valid <= 1'b0;
      cmd_op    <= '0;
      cmd_pot   <= 1'b0;
      cmd_reg   <= '0;
      cmd_data  <= '0;
      cmd_up    <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      if (cs_fall) begin
        st   <= ST_ID;
        bitn <= '0;
      end else if (take) begin
        sh   <= nb;
        bitn <= bitn + 3'd1;
        unique case (st)
          ST_ID: if (byte_done) st <= id_ok ? ST_INSTR : ST_DROP;
          ST_INSTR: if (byte_done) begin
            op_q  <= nb[7:4];
            reg_q <= nb[3:2];
            pot_q <= nb[0];
            if (nb[1]) begin
              st <= ST_DROP;
            end else if (op_is_xfer(nb[7:4]) || op_is_read(nb[7:4])) begin
              cmd_valid <= 1'b1;
              cmd_op    <= nb[7:4];
              cmd_reg   <= nb[3:2];
              cmd_pot   <= nb[0];
              st        <= op_is_read(nb[7:4]) ? ST_DATA : ST_DONE;
            end else if (op_is_write(nb[7:4])) begin
              st <= ST_DATA;
            end else if (nb[7:4] == OP_STEP) begin
              st <= ST_STEP;
            end else begin
              st <= ST_DROP;
            end
          end
          ST_DATA: if (byte_done) begin
            if (op_is_write(op_q)) begin
              cmd_valid <= 1'b1;
              cmd_op    <= op_q;
              cmd_reg   <= reg_q;
              cmd_pot   <= pot_q;
              cmd_data  <= nb[WORD_W-1:0];
            end
            st <= ST_DONE;
          end
          ST_STEP: begin
            cmd_valid <= 1'b1;
            cmd_op    <= OP_STEP;
            cmd_reg   <= reg_q;
            cmd_pot   <= pot_q;
            cmd_up    <= si_s;
          end
          default: ;
        endcase
      end
    end
  end

  // R8 / R9: a command only follows an unpaused edge inside an open frame
  assert_cmd_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($past(active) && !$past(paused)));

  assert_legal_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (op_is_xfer(cmd_op) || op_is_read(cmd_op) || op_is_write(cmd_op) || cmd_op == OP_STEP));

  assert_drop_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DROP) |=> !cmd_valid);
endmodule

// File: rtl/pot_readout.sv
module pot_readout
  import pot_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              sck_fall,
  input  logic              active,
  input  logic              paused,
  output logic              so,
  output logic              so_en
);
  logic [BYTE_W-1:0] sh;
  logic              armed, so_on, shift_en;

  assign shift_en = sck_fall & active & ~paused & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '0;
      armed <= 1'b0;
      so_on <= 1'b0;
      so    <= 1'b0;
    end else if (!active) begin
      armed <= 1'b0;
      so_on <= 1'b0;
    end else if (load) begin
      sh    <= load_byte;
      armed <= 1'b1;
    end else if (shift_en) begin
      so    <= sh[BYTE_W-1];
      sh    <= {sh[BYTE_W-2:0], 1'b0};
      so_on <= 1'b1;
    end
  end

  assign so_en = so_on & active & ~paused;

  assert_so_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (so_on && $past(so_on) && !$past(shift_en)) |-> $stable(so));
endmodule

// File: rtl/pot_cmd_if.sv
module pot_cmd_if
  import pot_cmd_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] TYPE_CODE   = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  input  logic [1:0]        dev_addr,
  output logic              so,
  output logic              so_en,
  output logic              cmd_valid,
  output logic [OP_W-1:0]   cmd_op,
  output logic              cmd_pot,
  output logic [1:0]        cmd_reg,
  output logic [WORD_W-1:0] cmd_data,
  output logic              cmd_up,
  input  logic [WORD_W-1:0] rd_data,
  input  logic              wip
);
  localparam int NPINS = 4;

  logic [NPINS-1:0] pin_q, pin_p;
  logic cs_s, sck_s, si_s, hold_s, sck_rise, sck_fall;
  logic active, paused, load;
  logic [BYTE_W-1:0] load_byte;

  pot_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({hold_n, si, sck, cs_n}), .q(pin_q), .q_prev(pin_p)
  );

  assign cs_s     = pin_q[0];
  assign sck_s    = pin_q[1];
  assign si_s     = pin_q[2];
  assign hold_s   = pin_q[3];
  assign sck_rise = pin_q[1] & ~pin_p[1];
  assign sck_fall = ~pin_q[1] & pin_p[1];

  pot_frame #(.TYPE_CODE(TYPE_CODE)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_prev(pin_p[0]), .sck_s(sck_s),
    .sck_rise(sck_rise), .si_s(si_s), .hold_s(hold_s), .dev_addr(dev_addr),
    .active(active), .paused(paused), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_pot(cmd_pot), .cmd_reg(cmd_reg), .cmd_data(cmd_data), .cmd_up(cmd_up)
  );

  assign load      = cmd_valid & op_is_read(cmd_op);
  assign load_byte = (cmd_op == OP_STATUS) ? {{(BYTE_W-1){1'b0}}, wip}
                                           : {{(BYTE_W-WORD_W){1'b0}}, rd_data};

  pot_readout u_readout (
    .clk(clk), .rst_n(rst_n), .load(load), .load_byte(load_byte), .sck_fall(sck_fall),
    .active(active), .paused(paused), .so(so), .so_en(so_en)
  );

  assert_so_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    so_en |-> !$past(cs_s));
endmodule

// File: tb/pot_cmd_if_test.sv
module pot_cmd_if_test;
  localparam int HALF = 8;
  localparam logic [7:0] ID = 8'h52;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic [1:0] dev_addr = 2'b10;
  logic so, so_en, cmd_valid, cmd_pot, cmd_up, wip = 1'b0;
  logic [3:0] cmd_op;
  logic [1:0] cmd_reg;
  logic [5:0] cmd_data, rd_data;
  logic [5:0] bwcr [2];
  logic [5:0] bdr [8];

  int checks = 0, errors = 0, ncmd = 0;
  logic [3:0] l_op [64];
  logic       l_pot [64];
  logic [1:0] l_reg [64];
  logic [5:0] l_data [64];
  logic       l_up [64];
  logic [7:0] rx;
  logic       en_seen;

  always #2.5 clk = ~clk;

  pot_cmd_if uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .dev_addr(dev_addr), .so(so), .so_en(so_en), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_pot(cmd_pot), .cmd_reg(cmd_reg), .cmd_data(cmd_data), .cmd_up(cmd_up),
    .rd_data(rd_data), .wip(wip)
  );

  assign rd_data = (cmd_op == 4'b1001) ? bwcr[cmd_pot] : bdr[{cmd_pot, cmd_reg}];

  always @(posedge clk) if (cmd_valid && ncmd < 64) begin
    l_op[ncmd] <= cmd_op; l_pot[ncmd] <= cmd_pot; l_reg[ncmd] <= cmd_reg;
    l_data[ncmd] <= cmd_data; l_up[ncmd] <= cmd_up; ncmd <= ncmd + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    si = b;
    wait_clk(HALF);
    rx = {rx[6:0], so};
    en_seen = so_en;
    sck = 1'b1;
    wait_clk(HALF);
    sck = 1'b0;
  endtask

  task automatic byte_out(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
  endtask

  task automatic cs_open();
    cs_n = 1'b0; wait_clk(HALF);
  endtask

  task automatic cs_close();
    wait_clk(HALF); cs_n = 1'b1; wait_clk(2 * HALF);
  endtask

  task automatic t_reset_and_powerup();
    check("R11 so_en after reset", so_en, 0);
    check("R11 cmd_valid after reset", cmd_valid, 0);
    byte_out(ID); byte_out(8'hD4);
    check("R11 no command before first select fall", ncmd, 0);
    cs_n = 1'b1; wait_clk(2 * HALF);
    check("R11 so_en with select high", so_en, 0);
  endtask

  task automatic t_id_reject();
    int base = ncmd;
    cs_open(); byte_out(8'h62); byte_out(8'hD4); byte_out(8'h00); cs_close();
    cs_open(); byte_out(8'h53); byte_out(8'hD4); cs_close();
    cs_open(); byte_out(8'h56); byte_out(8'h91); byte_out(8'h00);
    check("R1 no so_en after bad id", en_seen, 0);
    cs_close();
    check("R1 bad id frames silent", ncmd - base, 0);
  endtask

  task automatic t_transfers();
    int base = ncmd;
    cs_open(); byte_out(ID); byte_out(8'hD9); byte_out(8'hFF); cs_close();
    check("R3 one command for transfer", ncmd - base, 1);
    check("R2 op field", l_op[base], 4'hD);
    check("R2 reg field", l_reg[base], 2);
    check("R2 pot field", l_pot[base], 1);
    cs_open(); byte_out(ID); byte_out(8'h8C); cs_close();
    check("R3 global transfer count", ncmd - base, 2);
    check("R3 global op", l_op[base+1], 4'h8);
    check("R3 global reg", l_reg[base+1], 3);
  endtask

  task automatic t_writes();
    int base = ncmd;
    cs_open(); byte_out(ID); byte_out(8'hC4); byte_out(8'h2A); cs_close();
    check("R4 write reg count", ncmd - base, 1);
    check("R4 write reg data", l_data[base], 6'h2A);
    check("R4 write reg op", l_op[base], 4'hC);
    check("R4 write reg index", l_reg[base], 1);
    cs_open(); byte_out(ID); byte_out(8'hA1); byte_out(8'hFF); cs_close();
    check("R4 write wiper data", l_data[base+1], 6'h3F);
    check("R4 write wiper pot", l_pot[base+1], 1);
  endtask

  task automatic t_reads();
    bdr[7] = 6'h25; bwcr[0] = 6'h11;
    cs_open(); byte_out(ID); byte_out(8'hBD); byte_out(8'h00);
    check("R5 read reg byte", rx, 8'h25);
    check("R5 so_en in data phase", en_seen, 1);
    cs_close();
    check("R11 so_en released", so_en, 0);
    cs_open(); byte_out(ID); byte_out(8'h90); byte_out(8'h00); cs_close();
    check("R5 read wiper byte", rx, 8'h11);
    wip = 1'b1;
    cs_open(); byte_out(ID); byte_out(8'h51); byte_out(8'h00); cs_close();
    check("R6 status busy", rx, 8'h01);
    wip = 1'b0;
    cs_open(); byte_out(ID); byte_out(8'h51); byte_out(8'h00); cs_close();
    check("R6 status idle", rx, 8'h00);
  endtask

  task automatic t_steps();
    int base = ncmd;
    cs_open(); byte_out(ID); byte_out(8'h21);
    bit_out(1'b1); bit_out(1'b1); bit_out(1'b0);
    cs_close();
    check("R7 step count", ncmd - base, 3);
    check("R7 step op", l_op[base], 4'h2);
    check("R7 step pot", l_pot[base], 1);
    check("R7 first up", l_up[base], 1);
    check("R7 second up", l_up[base+1], 1);
    check("R7 third down", l_up[base+2], 0);
  endtask

  task automatic t_hold();
    int base;
    bdr[0] = 6'h2D;
    cs_open(); byte_out(ID); byte_out(8'hB0);
    bit_out(1'b0); bit_out(1'b0); bit_out(1'b0);
    wait_clk(HALF); hold_n = 1'b0; wait_clk(HALF);
    check("R8 so_en low while paused", so_en, 0);
    for (int i = 0; i < 3; i++) begin
      si = 1'b1; sck = 1'b1; wait_clk(HALF); sck = 1'b0; wait_clk(HALF);
    end
    hold_n = 1'b1; wait_clk(HALF);
    for (int i = 0; i < 5; i++) bit_out(1'b0);
    cs_close();
    check("R8 read resumes intact", rx, 8'h2D);
    base = ncmd;
    cs_open(); byte_out(ID); byte_out(8'h20);
    wait_clk(HALF); hold_n = 1'b0; wait_clk(HALF);
    for (int i = 0; i < 4; i++) begin
      si = 1'b1; sck = 1'b1; wait_clk(HALF); sck = 1'b0; wait_clk(HALF);
    end
    hold_n = 1'b1; wait_clk(HALF);
    check("R8 no steps while paused", ncmd - base, 0);
    bit_out(1'b0);
    cs_close();
    check("R8 step after resume", ncmd - base, 1);
  endtask

  task automatic t_truncated_and_illegal();
    int base = ncmd;
    cs_open(); byte_out(ID); byte_out(8'hC4); for (int i = 0; i < 4; i++) bit_out(1'b1); cs_close();
    cs_open(); byte_out(ID); for (int i = 0; i < 4; i++) bit_out(1'b1); cs_close();
    check("R9 truncated frames silent", ncmd - base, 0);
    cs_open(); byte_out(ID); byte_out(8'h70); byte_out(8'h00);
    check("R10 unknown op no so_en", en_seen, 0);
    cs_close();
    cs_open(); byte_out(ID); byte_out(8'hD2); cs_close();
    check("R10 unknown op and bit1 frames silent", ncmd - base, 0);
  endtask

  initial begin
    bwcr[0] = '0; bwcr[1] = '0;
    for (int i = 0; i < 8; i++) bdr[i] = '0;
    rx = '0; en_seen = 1'b0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset_and_powerup();
    t_id_reject();
    t_transfers();
    t_writes();
    t_reads();
    t_steps();
    t_hold();
    t_truncated_and_illegal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule